// File: doc/BRIEF.md
# Programmable Interval Timer

A byte-wide timer with several 16-bit down-counting channels. The channels share one control port and one data port. Software writes a control byte to pick a channel. That byte either freezes a snapshot of the channel's count or sets the channel's counting mode.

Each channel's count is loaded through its data address, low byte first and then high byte. Reads of the count return bytes in the same low-then-high order. The count is either the live value or the frozen snapshot. Counting advances once for each pulse on a shared tick enable, which in the intended system runs at about 1.19 MHz.

Each channel has one output. In the terminal-count mode the output rises when the count reaches zero, and the count then stops. The two periodic modes reload the programmed period and leave the output alone. Control bytes that ask for a feature the block does not build raise a one-cycle error flag and change nothing. Those features are snapshot-of-all, BCD counting, single-byte access, and any other mode.

Top module: `pit_timer`

## Requirements
- R1: After reset every channel output and the error flag are low, and a low/high read pair of any channel returns 0x00, 0x00.
- R2: A data write to channel address c (0..NUM_CH-1) stores the low count byte, and the next one stores the high byte. A data read returns the low byte and then the high byte. Each read result appears on `rdData` one clock after the read strobe.
- R3: A loaded channel with a nonzero period decrements by one on each clock where `tickEn` is high. It holds its value on clocks without `tickEn`.
- R4: In mode 0, the tick that takes the count from 1 to 0 drives the output high. The count then stays at 0.
- R5: A low-byte write stops any countdown and drives the output low. Ticks have no effect until the high byte is written.
- R6: A high-byte write that leaves the 16-bit period at zero does not start counting.
- R7: A control byte with the access field (bits 5:4) equal to 0 freezes the count of the channel chosen by bits 7:6. Reads then return the frozen value. The high-byte read releases it, and later reads return the live count.
- R8: A freeze command issued while a snapshot is still pending is ignored. The snapshot and the read byte position are kept.
- R9: In modes 2 and 3, the tick that would reach zero reloads the period instead. The output stays unchanged.
- R10: These control bytes pulse `cfgErr` high for one clock and leave the channel's mode unchanged: select 3, access 1 or 2, BCD bit 0 set, or a mode field (bits 3:1) other than 0, 2 or 3 with access 3.
- R11: A command or data access affects only the channel it addresses. Ticks advance every running channel independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counting tick enable |
| wrEn | input | 1 | Bus write strobe |
| rdEn | input | 1 | Bus read strobe (ignored when wrEn is high) |
| addr | input | 2 | 0..NUM_CH-1 channel data, 3 control |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Registered read byte |
| timerOut | output | NUM_CH | Per-channel output |
| cfgErr | output | 1 | One-cycle pulse after an unsupported control byte |

## Verification
The bench builds the block with its default of three channels. All three select codes are therefore live and the fourth code hits the unsupported snapshot-of-all path. With three channels, one channel in terminal-count mode and two in the periodic modes can run side by side. A stopped channel can be left pending to show that shared ticks do not disturb it. Short periods keep terminal count and reload reachable within a few ticks. A load of 0x0110 shows the borrow from the high byte.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int BUS_W = 8;

  localparam logic [2:0] MODE_TC   = 3'd0;
  localparam logic [2:0] MODE_RATE = 3'd2;
  localparam logic [2:0] MODE_SQ   = 3'd3;

  localparam logic [1:0] ACC_LATCH = 2'd0;
  localparam logic [1:0] ACC_WORD  = 2'd3;

  typedef struct packed {
    logic       dataWr;
    logic       dataRd;
    logic       latchCmd;
    logic       modeSet;
    logic [2:0] modeVal;
  } chanCmd_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BUS_W-1:0]            wrData,
  output chanCmd_t [NUM_CH-1:0]       cmd,
  output logic                        cfgErr
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};

  logic       ctrlWr;
  logic [1:0] selF;
  logic [1:0] accF;
  logic [2:0] modeF;
  logic       bcdF;
  logic       modeOk;
  logic       badWord;
  logic       rdOnly;

  assign ctrlWr = wrEn && (addr == CTRL_ADDR);
  assign rdOnly = rdEn && !wrEn;
  assign selF   = wrData[7:6];
  assign accF   = wrData[5:4];
  assign modeF  = wrData[3:1];
  assign bcdF   = wrData[0];
  assign modeOk = (modeF == MODE_TC) || (modeF == MODE_RATE) || (modeF == MODE_SQ);

  always_comb begin
    badWord = 1'b0;
    if (selF == 2'd3 || int'(selF) >= NUM_CH) badWord = 1'b1;
    else if (accF != ACC_LATCH) begin
      if (accF != ACC_WORD || !modeOk || bcdF) badWord = 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic hitCtrl;
    assign hitCtrl            = ctrlWr && !badWord && (int'(selF) == c);
    assign cmd[c].dataWr      = wrEn && (int'(addr) == c);
    assign cmd[c].dataRd      = rdOnly && (int'(addr) == c);
    assign cmd[c].latchCmd    = hitCtrl && (accF == ACC_LATCH);
    assign cmd[c].modeSet     = hitCtrl && (accF == ACC_WORD);
    assign cmd[c].modeVal     = modeF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= ctrlWr && badWord;
  end

  logic [NUM_CH-1:0] chanBusy;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_busy
    assign chanBusy[c] = cmd[c].dataWr | cmd[c].dataRd | cmd[c].latchCmd | cmd[c].modeSet;
  end

  // R11: a single bus access reaches at most one channel
  p_one_chan_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanBusy));

  // R10: the error pulse only follows a control write
  p_err_after_ctrl_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> $past(ctrlWr));
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int BYTE_W = BUS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  chanCmd_t          cmd,
  input  logic [BYTE_W-1:0] busData,
  output logic [BYTE_W-1:0] rdByte,
  output logic              outHigh
);
  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] latchVal;
  logic             latchOn;
  logic             rdMsb;
  logic             wrMsb;
  logic             running;
  logic [2:0]       mode;
  logic [CNT_W-1:0] rdSrc;
  logic [CNT_W-1:0] newPeriod;

  assign rdSrc     = latchOn ? latchVal : count;
  assign rdByte    = rdMsb ? rdSrc[CNT_W-1:BYTE_W] : rdSrc[BYTE_W-1:0];
  assign newPeriod = {busData, count[BYTE_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      period   <= '0;
      latchVal <= '0;
      latchOn  <= 1'b0;
      rdMsb    <= 1'b0;
      wrMsb    <= 1'b0;
      running  <= 1'b0;
      outHigh  <= 1'b0;
      mode     <= MODE_TC;
    end else begin
      if (cmd.modeSet) mode <= cmd.modeVal;

      if (cmd.latchCmd) begin
        if (!latchOn) begin
          latchOn  <= 1'b1;
          latchVal <= count;
          rdMsb    <= 1'b0;
        end
      end else if (cmd.dataRd) begin
        rdMsb <= !rdMsb;
        if (rdMsb && latchOn) latchOn <= 1'b0;
      end

      if (cmd.dataWr) begin
        if (!wrMsb) begin
          count[BYTE_W-1:0] <= busData;
          running <= 1'b0;
          outHigh <= 1'b0;
          wrMsb   <= 1'b1;
        end else begin
          count[CNT_W-1:BYTE_W] <= busData;
          period  <= newPeriod;
          running <= (newPeriod != '0);
          wrMsb   <= 1'b0;
        end
      end else if (running && tickEn) begin
        if (count == ONE) begin
          if (mode == MODE_TC) begin
            count   <= '0;
            running <= 1'b0;
            outHigh <= 1'b1;
          end else begin
            count <= period;
          end
        end else begin
          count <= count - ONE;
        end
      end
    end
  end

  // R3: no tick, no write -> count holds
  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !cmd.dataWr) |=> $stable(count));

  // R4: output rises only on a tick in terminal-count mode
  p_out_rise_tc_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outHigh) |-> ($past(tickEn) && $past(mode) == MODE_TC));

  // R5: low-byte write halts and clears the output
  p_lsb_halts_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.dataWr && !wrMsb) |=> (!running && !outHigh));

  // R8: a pending snapshot is not overwritten
  p_latch_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (latchOn && !cmd.dataRd) |=> (latchOn && $stable(latchVal)));

  // R9: periodic modes never raise the output
  p_periodic_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_TC && !cmd.dataWr && !cmd.modeSet) |=> !$rose(outHigh));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic [NUM_CH-1:0] timerOut,
  output logic              cfgErr
);
  chanCmd_t [NUM_CH-1:0]            cmd;
  logic [NUM_CH-1:0][BUS_W-1:0]     rdVec;

  pit_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cmd(cmd), .cfgErr(cfgErr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
    pit_counter #(.BYTE_W(BUS_W)) u_cnt (
      .clk(clk), .rstN(rstN), .tickEn(tickEn), .cmd(cmd[c]),
      .busData(wrData), .rdByte(rdVec[c]), .outHigh(timerOut[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (rdEn && !wrEn && int'(addr) < NUM_CH) rdData <= rdVec[addr];
  end
endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [2:0] timerOut;
  logic cfgErr;

  int nRun = 0, nFail = 0;
  logic [7:0] expQ[$];
  string tagQ[$];
  logic rdFire = 1'b0;

  always #2.5 clk = ~clk;

  pit_timer i_pit_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .timerOut(timerOut), .cfgErr(cfgErr)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    addr = a; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(posedge clk); @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  // monitor: scoreboard of read bytes
  always @(posedge clk) rdFire <= rdEn && !wrEn;
  always @(negedge clk) begin
    if (rdFire) begin
      if (expQ.size() == 0) check(1'b0, "scoreboard underflow", rdData, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(timerOut == 3'b000, "R1 outputs after reset", timerOut, 0);
    check(cfgErr == 1'b0, "R1 error flag after reset", cfgErr, 0);
    busRd(2'd0, 8'h00, "R1 ch0 low byte");
    busRd(2'd0, 8'h00, "R1 ch0 high byte");
    busRd(2'd2, 8'h00, "R1 ch2 low byte");
    busRd(2'd2, 8'h00, "R1 ch2 high byte");

    // R2/R3/R4: ch0 mode 0, count 5
    busWr(2'd3, 8'h30);
    busWr(2'd0, 8'h05); busWr(2'd0, 8'h00);
    busRd(2'd0, 8'h05, "R2 load low");
    busRd(2'd0, 8'h00, "R2 load high");
    ticks(2);
    busRd(2'd0, 8'h03, "R3 two ticks low");
    busRd(2'd0, 8'h00, "R3 two ticks high");
    idle(3);
    busRd(2'd0, 8'h03, "R3 hold without tick");
    busRd(2'd0, 8'h00, "R3 hold high");
    ticks(2);
    check(timerOut[0] == 1'b0, "R4 output low at count 1", timerOut[0], 0);
    ticks(1);
    check(timerOut[0] == 1'b1, "R4 output high at terminal count", timerOut[0], 1);
    ticks(3);
    busRd(2'd0, 8'h00, "R4 count stays zero low");
    busRd(2'd0, 8'h00, "R4 count stays zero high");
    check(timerOut[0] == 1'b1, "R4 output stays high", timerOut[0], 1);

    // R5: low write halts and clears output
    busWr(2'd0, 8'h10);
    check(timerOut[0] == 1'b0, "R5 low write clears output", timerOut[0], 0);
    ticks(3);
    busRd(2'd0, 8'h10, "R5 halted low");
    busRd(2'd0, 8'h00, "R5 halted high");
    busWr(2'd0, 8'h01);
    ticks(17);
    busRd(2'd0, 8'hFF, "R2 borrow low");
    busRd(2'd0, 8'h00, "R2 borrow high");

    // R6: zero period
    busWr(2'd0, 8'h00); busWr(2'd0, 8'h00);
    ticks(3);
    busRd(2'd0, 8'h00, "R6 zero period low");
    busRd(2'd0, 8'h00, "R6 zero period high");
    check(timerOut[0] == 1'b0, "R6 output low", timerOut[0], 0);

    // R7/R8: snapshot
    busWr(2'd0, 8'h34); busWr(2'd0, 8'h12);
    busWr(2'd3, 8'h00);
    ticks(4);
    busRd(2'd0, 8'h34, "R7 frozen low");
    ticks(2);
    busWr(2'd3, 8'h00);
    busRd(2'd0, 8'h12, "R8 second freeze ignored high");
    busRd(2'd0, 8'h2E, "R7 released live low");
    busRd(2'd0, 8'h12, "R7 released live high");
    busWr(2'd0, 8'h00); // halt ch0 at 0x1200

    // R9: ch1 mode 2, ch2 mode 3
    busWr(2'd3, 8'h74);
    busWr(2'd1, 8'h03); busWr(2'd1, 8'h00);
    ticks(3);
    busRd(2'd1, 8'h03, "R9 mode2 reload low");
    busRd(2'd1, 8'h00, "R9 mode2 reload high");
    check(timerOut[1] == 1'b0, "R9 mode2 output unchanged", timerOut[1], 0);
    ticks(1);
    busRd(2'd1, 8'h02, "R9 mode2 after reload low");
    busRd(2'd1, 8'h00, "R9 mode2 after reload high");
    busWr(2'd3, 8'hB6);
    busWr(2'd2, 8'h02); busWr(2'd2, 8'h00);
    ticks(2);
    busRd(2'd2, 8'h02, "R9 mode3 reload low");
    busRd(2'd2, 8'h00, "R9 mode3 reload high");
    check(timerOut[2] == 1'b0, "R9 mode3 output unchanged", timerOut[2], 0);
    busRd(2'd1, 8'h03, "R11 ch1 independent low");
    busRd(2'd1, 8'h00, "R11 ch1 independent high");

    // R10: unsupported words
    busWr(2'd3, 8'h71);
    check(cfgErr == 1'b1, "R10 BCD word flagged", cfgErr, 1);
    idle(1);
    check(cfgErr == 1'b0, "R10 flag is one cycle", cfgErr, 0);
    busWr(2'd3, 8'h50);
    check(cfgErr == 1'b1, "R10 access 1 flagged", cfgErr, 1);
    busWr(2'd3, 8'hC0);
    check(cfgErr == 1'b1, "R10 select 3 flagged", cfgErr, 1);
    busWr(2'd3, 8'h72);
    check(cfgErr == 1'b1, "R10 mode 1 flagged", cfgErr, 1);
    busWr(2'd3, 8'hB6);
    check(cfgErr == 1'b0, "R10 legal word not flagged", cfgErr, 0);
    busWr(2'd1, 8'h02); busWr(2'd1, 8'h00);
    ticks(2);
    busRd(2'd1, 8'h02, "R10 ch1 mode kept low");
    busRd(2'd1, 8'h00, "R10 ch1 mode kept high");
    check(timerOut[1] == 1'b0, "R10 ch1 output not raised", timerOut[1], 0);

    // R11: halted ch0 untouched by ticks and other channels
    busRd(2'd0, 8'h00, "R11 ch0 untouched low");
    busRd(2'd0, 8'h12, "R11 ch0 untouched high");
    idle(2);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule